// File: doc/BRIEF.md
# Dual-Rail Filter Coefficient Store with Indirect Host Access

This block keeps the coefficient table of one filter channel. Each of the 256 entries has an I value and a Q value. The filter datapath reads the table through a registered read port. The host cannot address the RAM directly. It works through three registers on a small write bus:

- a control register, which holds the ownership bit and the format bit;
- a data register, which feeds a staging chain;
- an address/command register, whose write is the access strobe.

Before any table access, the host sets the ownership bit. While that bit is set, the host owns the RAM and the datapath does not. Clearing the bit hands the RAM back to the datapath.

Two formats are supported. In fixed mode each rail is a 16-bit two's-complement word. In floating mode each rail has a 20-bit mantissa and a 4-bit shift. The low mantissa nibbles and both shifts share one packed staging word. Packed word layout:

| Bits | Field |
|------|-------|
| 15:12 | I mantissa bits 3:0 |
| 11:8 | I shift |
| 7:4 | Q mantissa bits 3:0 |
| 3:0 | Q shift |

Each accepted strobe starts a recovery window of four cycles. During that window the block reports busy and ignores data and address writes.

Top module: `coef_ram_port`

## Requirements
- R1: After reset, the ownership bit and the format bit are clear, `busy` is 0, and `host_rdata` is 0.
- R2: A write to offset 0x0c sets the ownership bit from data bit 12 and the format bit from data bit 13 (1 = floating). Control writes are accepted even while busy.
- R3: In fixed mode, two writes to offset 0x14 (Q first, then I) followed by a write to offset 0x15 with bit 15 = 0 store I and Q at the location given by bits 7:0. The packed field of that entry becomes 0.
- R4: In floating mode, three writes to offset 0x14 are staged in this order: the packed word, then Q mantissa bits 19:4, then I mantissa bits 19:4. One write-strobe stores all three.
- R5: A write to offset 0x15 with bit 15 = 1 is a read strobe. From the second cycle after the strobe, `host_rdata` shows one field of the addressed entry, chosen by bits 9:8: 01 = I high word, 10 = Q high word, 11 = packed word, 00 = zero.
- R6: Address word bits 14:10 have no effect on the location or on the data.
- R7: `busy` rises on the cycle after an accepted strobe and stays high for exactly 4 cycles. Writes to offset 0x14 or 0x15 while `busy` is high are ignored.
- R8: A strobe issued while the ownership bit is clear is discarded. It changes no entry and does not raise `busy`.
- R9: While the ownership bit is clear, `host_rdata` is 0 and `dp_addr` drives the RAM. One cycle after `dp_addr` is presented, the datapath outputs are `dp_i_coef = {I, packed[15:12]}`, `dp_i_shift = packed[11:8]`, `dp_q_coef = {Q, packed[7:4]}` and `dp_q_shift = packed[3:0]`.
- R10: Every data write shifts the staging chain. A commit uses only the most recent two words (fixed mode) or three words (floating mode); older writes are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write enable |
| host_reg | input | 8 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected field of the addressed entry, or zero |
| busy | output | 1 | Recovery window after a strobe |
| dp_addr | input | 8 | Datapath read location |
| dp_i_coef | output | 20 | I mantissa for the datapath |
| dp_i_shift | output | 4 | I shift for the datapath |
| dp_q_coef | output | 20 | Q mantissa for the datapath |
| dp_q_shift | output | 4 | Q shift for the datapath |

## Verification
The assertions check, on every cycle, the following properties:

- an accepted strobe raises `busy` on the next cycle;
- no busy run lasts longer than the recovery gap;
- a strobe without host ownership leaves `busy` low;
- the ownership bit follows control writes;
- the read bus is zero whenever ownership is clear or lane 00 is selected.

Only the bench scenarios can show data integrity. The bench sweeps every location in both formats and compares each lane with arithmetic patterns. It checks that writes during the busy window are dropped. It checks that surplus staging words are discarded, that spare address bits are ignored, and that discarded strobes leave the datapath view of the table unchanged.

// File: rtl/coef_ram_port.sv
module coef_ram_port #(
  parameter int AW        = 8,
  parameter int SW        = 4,
  parameter int DW        = 4 * SW,
  parameter int GAP       = 4,
  parameter int LANE_LSB  = 8,
  parameter int HOLD_BIT  = 12,
  parameter int FLOAT_BIT = 13,
  parameter logic [7:0] CTRL_OFS = 8'h0c,
  parameter logic [7:0] DATA_OFS = 8'h14,
  parameter logic [7:0] ADDR_OFS = 8'h15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [7:0]    host_reg,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          busy,
  input  logic [AW-1:0] dp_addr,
  output logic [DW+SW-1:0] dp_i_coef,
  output logic [SW-1:0]    dp_i_shift,
  output logic [DW+SW-1:0] dp_q_coef,
  output logic [SW-1:0]    dp_q_shift
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = 3 * DW;
  localparam int CW    = $clog2(GAP + 1);

  logic          hold_q, float_q;
  logic [DW-1:0] stg0, stg1, stg2;
  logic [AW-1:0] loc_q;
  logic [1:0]    lane_q;
  logic [CW-1:0] gap_cnt;
  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rd_q;

  logic wr_ctrl, wr_data, strobe, commit;
  logic [AW-1:0] raddr;
  logic [EW-1:0] entry;

  assign busy    = gap_cnt != '0;
  assign wr_ctrl = host_we && host_reg == CTRL_OFS;
  assign wr_data = host_we && host_reg == DATA_OFS && !busy;
  assign strobe  = host_we && host_reg == ADDR_OFS && !busy && hold_q;
  assign commit  = strobe && !host_wdata[DW-1];
  assign entry   = {stg0, stg1, float_q ? stg2 : {DW{1'b0}}};
  assign raddr   = hold_q ? loc_q : dp_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      float_q <= 1'b0;
      stg0    <= '0;
      stg1    <= '0;
      stg2    <= '0;
      loc_q   <= '0;
      lane_q  <= '0;
      gap_cnt <= '0;
    end else begin
      if (wr_ctrl) begin
        hold_q  <= host_wdata[HOLD_BIT];
        float_q <= host_wdata[FLOAT_BIT];
      end
      if (wr_data) begin
        stg2 <= stg1;
        stg1 <= stg0;
        stg0 <= host_wdata;
      end
      if (strobe) begin
        loc_q   <= host_wdata[AW-1:0];
        lane_q  <= host_wdata[LANE_LSB +: 2];
        gap_cnt <= CW'(GAP);
      end else if (busy) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[host_wdata[AW-1:0]] <= entry;
    rd_q <= mem[raddr];
  end

  always_comb begin
    host_rdata = '0;
    if (hold_q) begin
      case (lane_q)
        2'b01:   host_rdata = rd_q[EW-1 -: DW];
        2'b10:   host_rdata = rd_q[2*DW-1 -: DW];
        2'b11:   host_rdata = rd_q[DW-1:0];
        default: host_rdata = '0;
      endcase
    end
  end

  assign dp_i_coef  = {rd_q[EW-1 -: DW],   rd_q[4*SW-1 -: SW]};
  assign dp_i_shift = rd_q[3*SW-1 -: SW];
  assign dp_q_coef  = {rd_q[2*DW-1 -: DW], rd_q[2*SW-1 -: SW]};
  assign dp_q_shift = rd_q[SW-1:0];
endmodule

// File: rtl/coef_ram_port_chk.sv
module coef_ram_port_chk #(
  parameter int DW  = 16,
  parameter int GAP = 4,
  parameter int HOLD_BIT = 12,
  parameter logic [7:0] CTRL_OFS = 8'h0c,
  parameter logic [7:0] ADDR_OFS = 8'h15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_we,
  input logic [7:0]    host_reg,
  input logic [DW-1:0] host_wdata,
  input logic [DW-1:0] host_rdata,
  input logic          busy,
  input logic          hold_q,
  input logic [1:0]    lane_q
);
  logic [7:0] run_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_reg == ADDR_OFS && hold_q && !busy) |=> busy);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 8'(GAP));

  // R8
  no_own_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_reg == ADDR_OFS && !hold_q && !busy) |=> !busy);

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> host_rdata == '0);

  // R5
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && lane_q == 2'b00) |-> host_rdata == '0);

  // R2
  hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_reg == CTRL_OFS) |=> hold_q == $past(host_wdata[HOLD_BIT]));
endmodule

bind coef_ram_port coef_ram_port_chk #(
  .DW(DW), .GAP(GAP), .HOLD_BIT(HOLD_BIT), .CTRL_OFS(CTRL_OFS), .ADDR_OFS(ADDR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_reg(host_reg),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
  .hold_q(hold_q), .lane_q(lane_q)
);

// File: tb/coef_ram_port_tb.sv
module coef_ram_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_reg = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy;
  logic [7:0]  dp_addr = '0;
  logic [19:0] dp_i_coef, dp_q_coef;
  logic [3:0]  dp_i_shift, dp_q_shift;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  coef_ram_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_reg(host_reg),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .dp_addr(dp_addr), .dp_i_coef(dp_i_coef), .dp_i_shift(dp_i_shift),
    .dp_q_coef(dp_q_coef), .dp_q_shift(dp_q_shift)
  );

  function automatic logic [15:0] fx_q(int a); return 16'(a * 257) ^ 16'h5a3c; endfunction
  function automatic logic [15:0] fx_i(int a); return 16'(a * 97 + 16'h1357); endfunction
  function automatic logic [15:0] fl_p(int a); return 16'(a * 16'h0123) ^ 16'hf00f; endfunction
  function automatic logic [15:0] fl_q(int a); return 16'(a * 181) ^ 16'h8001; endfunction
  function automatic logic [15:0] fl_i(int a); return 16'(a * 613 + 16'h2468); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] r, logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_reg = r; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic strobe_wait(logic [15:0] w);
    reg_wr(8'h15, w);
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_lane(int a, logic [1:0] lane, output logic [15:0] v);
    reg_wr(8'h15, 16'h8000 | (16'(lane) << 8) | 16'(a));
    @(negedge clk);
    v = host_rdata;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 rdata", host_rdata, 0);

    reg_wr(8'h0c, 16'h1000);
    for (int a = 0; a < 256; a++) begin
      reg_wr(8'h14, fx_q(a));
      reg_wr(8'h14, fx_i(a));
      strobe_wait(16'(a));
    end
    for (int a = 0; a < 256; a++) begin
      rd_lane(a, 2'b01, v); check("R3 I lane", v, fx_i(a));
      rd_lane(a, 2'b10, v); check("R3 Q lane", v, fx_q(a));
      if (a % 16 == 0) begin
        rd_lane(a, 2'b11, v); check("R3 packed zero", v, 0);
        rd_lane(a, 2'b00, v); check("R5 lane 00", v, 0);
      end
    end

    reg_wr(8'h15, 16'h8100);
    check("R7 busy rise", busy, 1);
    repeat (3) @(negedge clk);
    check("R7 busy 4th", busy, 1);
    @(negedge clk);
    check("R7 busy end", busy, 0);

    reg_wr(8'h0c, 16'h3000);
    for (int a = 0; a < 256; a++) begin
      reg_wr(8'h14, fl_p(a));
      reg_wr(8'h14, fl_q(a));
      reg_wr(8'h14, fl_i(a));
      strobe_wait(16'(a));
    end
    for (int a = 0; a < 256; a++) begin
      rd_lane(a, 2'b01, v); check("R4 I mant", v, fl_i(a));
      rd_lane(a, 2'b10, v); check("R4 Q mant", v, fl_q(a));
      rd_lane(a, 2'b11, v); check("R4 packed", v, fl_p(a));
    end

    reg_wr(8'h14, 16'hdead);
    reg_wr(8'h14, 16'h1111);
    reg_wr(8'h14, 16'h2222);
    reg_wr(8'h14, 16'h3333);
    strobe_wait(16'd5);
    rd_lane(5, 2'b11, v); check("R10 oldest kept", v, 16'h1111);
    rd_lane(5, 2'b10, v); check("R10 middle", v, 16'h2222);
    rd_lane(5, 2'b01, v); check("R10 newest", v, 16'h3333);

    reg_wr(8'h14, 16'h0a0b);
    reg_wr(8'h14, 16'h0c0d);
    reg_wr(8'h14, 16'h0e0f);
    strobe_wait(16'h7c07);
    reg_wr(8'h15, 16'hfd07);
    @(negedge clk);
    check("R6 spare bits read", host_rdata, 16'h0e0f);
    repeat (3) @(negedge clk);
    rd_lane(7, 2'b11, v); check("R6 spare bits write", v, 16'h0a0b);

    reg_wr(8'h14, 16'h4444);
    reg_wr(8'h14, 16'h5555);
    reg_wr(8'h14, 16'h6666);
    reg_wr(8'h15, 16'h0009);
    reg_wr(8'h14, 16'hbad0);
    reg_wr(8'h15, 16'h8109);
    repeat (3) @(negedge clk);
    rd_lane(9, 2'b01, v); check("R7 data write dropped", v, 16'h6666);
    reg_wr(8'h15, 16'h8109);
    reg_wr(8'h15, 16'h8209);
    @(negedge clk);
    check("R7 addr write dropped", host_rdata, 16'h6666);
    repeat (3) @(negedge clk);

    reg_wr(8'h0c, 16'h2000);
    check("R9 rdata idle", host_rdata, 0);
    check("R2 float keeps", busy, 0);
    reg_wr(8'h14, 16'h7777);
    reg_wr(8'h14, 16'h8888);
    reg_wr(8'h14, 16'h9999);
    reg_wr(8'h15, 16'h000b);
    check("R8 no busy", busy, 0);
    for (int a = 0; a < 256; a++) begin
      logic [15:0] ei, eq, ep;
      ei = fl_i(a); eq = fl_q(a); ep = fl_p(a);
      if (a == 5) begin ei = 16'h3333; eq = 16'h2222; ep = 16'h1111; end
      if (a == 7) begin ei = 16'h0e0f; eq = 16'h0c0d; ep = 16'h0a0b; end
      if (a == 9) begin ei = 16'h6666; eq = 16'h5555; ep = 16'h4444; end
      @(negedge clk);
      dp_addr = 8'(a);
      @(negedge clk);
      check(a == 11 ? "R8 entry unchanged" : "R9 dp I", dp_i_coef, {ei, ep[15:12]});
      check("R9 dp I shift", dp_i_shift, 32'(ep[11:8]));
      check("R9 dp Q", dp_q_coef, {eq, ep[7:4]});
      check("R9 dp Q shift", dp_q_shift, 32'(ep[3:0]));
    end

    reg_wr(8'h0c, 16'h1000);
    rd_lane(11, 2'b01, v); check("R2 hold back, R8 I", v, fl_i(11));
    rd_lane(11, 2'b11, v); check("R2 fixed mode readback", v, fl_p(11));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule